// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers a set of peripheral interrupt lines into one CPU interrupt request. The lines are split into two equal banks, low and high, and each bank has a pending-status register and an enable register. A rising line sets its pending bit and a falling line clears it. Software can also drop a pending bit by writing a one to that bank's clear register. The CPU request is the OR of the enabled pending bits of both banks. It is registered, so it follows any change in status or enable after one clock.

Software reaches the registers over a simple single-cycle register bus that uses word-aligned byte offsets. Reading a bank's status register returns only the pending bits that are also enabled. Two reserved offsets take any access quietly. Any other offset does nothing, reads as zero and raises a one-cycle error pulse.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, every status and enable register is zero, and irq_o, rdata_o and err_o are all low.
- R2: Bit i of each bank stands for line i of that bank (irq_lo_i[i], irq_hi_i[i]). A 0-to-1 change of a line, sampled at a clock edge, sets that status bit. A 1-to-0 change clears it.
- R3: irq_o is high exactly one clock after a cycle in which (status_lo & enable_lo) | (status_hi & enable_hi) is non-zero. Enabling a line that is already pending raises it, and disabling the last enabled pending line drops it.
- R4: A read of offset 0x20 returns status_lo & enable_lo, and a read of 0x10 returns status_hi & enable_hi. Writes to these two offsets change no state.
- R5: Offset 0x24 (low) and offset 0x14 (high) hold the enable registers. A write replaces all bits, and a read returns the stored value.
- R6: A write to 0x28 (low) or 0x18 (high) clears each status bit of that bank where the write data holds a 1. Reads of these offsets return zero.
- R7: If a line rises in the same cycle as a clear write hits its bit, the bit ends up set.
- R8: Offsets 0x1c and 0x2c accept reads and writes with no effect. Reads return zero and err_o stays low.
- R9: An access to any other offset, including one that is not word-aligned, changes no state and reads as zero. err_o is high in the cycle after that access.
- R10: rdata_o carries the read value in the cycle after rd_i is high, and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lo_i | input | 32 | Low-bank interrupt lines |
| irq_hi_i | input | 32 | High-bank interrupt lines |
| addr_i | input | 8 | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| err_o | output | 1 | One-cycle pulse after an access to an unmapped offset |
| irq_o | output | 1 | Combined CPU interrupt request, registered |

## Verification
The bench builds the block with its default parameters: 32-bit banks, an 8-bit offset space, and bank bases 0x20 (low) and 0x10 (high). With full 32-bit banks the bench can drive the top bit and mixed enable patterns, and can run a whole-register replace. The 8-bit offset space lets it reach unmapped, unaligned and reserved offsets next to the mapped ones. Each cycle the bench checks a behavioural model against irq_o, rdata_o and err_o. This holds through directed sequences and through a random mix of line toggles and bus accesses. The directed sequences include a clear write that lands in the same cycle as a rising edge on the line it clears.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_LO   = 0;
  localparam int unsigned BANK_HI   = 1;

  // per-bank register select, word index within a 16-byte bank window
  typedef struct packed {
    logic stat;
    logic en;
    logic clr;
    logic rsv;
  } bank_sel_t;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_BASE = 'h20,
  parameter logic [ADDR_W-1:0] HI_BASE = 'h10
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       acc_i,
  output bank_sel_t [NUM_BANKS-1:0]  sel_o,
  output logic                       hit_o
);
  localparam int unsigned WIN_LSB = 4;

  logic [NUM_BANKS-1:0] bank_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = (b == BANK_LO) ? LO_BASE : HI_BASE;
    always_comb begin
      sel_o[b]    = '0;
      bank_hit[b] = acc_i && (addr_i[1:0] == 2'b00) &&
                    (addr_i[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
      if (bank_hit[b]) begin
        unique case (addr_i[3:2])
          2'd0: sel_o[b].stat = 1'b1;
          2'd1: sel_o[b].en   = 1'b1;
          2'd2: sel_o[b].clr  = 1'b1;
          default: sel_o[b].rsv = 1'b1;
        endcase
      end
    end
  end

  assign hit_o = |bank_hit;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] line_i,
  input  logic              en_we_i,
  input  logic              clr_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] enable_o,
  output logic [BANK_W-1:0] pend_o
);
  logic [BANK_W-1:0] line_q, rise, fall, clr_mask, status_d;

  assign rise     = line_i & ~line_q;
  assign fall     = ~line_i & line_q;
  assign clr_mask = clr_we_i ? wdata_i : '0;
  // a rising line beats a same-cycle clear
  assign status_d = (status_o & ~clr_mask & ~fall) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      status_o <= '0;
      enable_o <= '0;
    end else begin
      line_q   <= line_i;
      status_o <= status_d;
      if (en_we_i) enable_o <= wdata_i;
    end
  end

  assign pend_o = status_o & enable_o;

  // R5
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> enable_o == $past(wdata_i));

  // R6
  clr_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (status_o & $past(wdata_i & ~rise)) == '0);

  // R7
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> (status_o & $past(rise)) == $past(rise));

  // R2
  fall_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall) |=> (status_o & $past(fall)) == '0);
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_BASE = 'h20,
  parameter logic [ADDR_W-1:0] HI_BASE = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] irq_lo_i,
  input  logic [BANK_W-1:0] irq_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_o
);
  bank_sel_t [NUM_BANKS-1:0] sel;
  logic                      hit, acc;
  logic [BANK_W-1:0]         lines   [NUM_BANKS];
  logic [BANK_W-1:0]         status  [NUM_BANKS];
  logic [BANK_W-1:0]         enable  [NUM_BANKS];
  logic [BANK_W-1:0]         pend    [NUM_BANKS];
  logic [BANK_W-1:0]         rd_val;
  logic                      any_pend;

  assign acc             = rd_i | wr_i;
  assign lines[BANK_LO]  = irq_lo_i;
  assign lines[BANK_HI]  = irq_hi_i;

  irq_agg_decode #(
    .ADDR_W (ADDR_W),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .acc_i (acc),
    .sel_o (sel),
    .hit_o (hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_agg_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (lines[b]),
      .en_we_i (wr_i && sel[b].en),
      .clr_we_i(wr_i && sel[b].clr),
      .wdata_i (wdata_i),
      .status_o(status[b]),
      .enable_o(enable[b]),
      .pend_o  (pend[b])
    );
  end

  always_comb begin
    rd_val   = '0;
    any_pend = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      any_pend = any_pend | (|pend[b]);
      if (sel[b].stat) rd_val = rd_val | pend[b];
      if (sel[b].en)   rd_val = rd_val | enable[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_i ? rd_val : '0;
      err_o   <= acc && !hit;
      irq_o   <= any_pend;
    end
  end

  // R3
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend[BANK_LO] | pend[BANK_HI])));

  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !hit) |=> err_o);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit) |=> rdata_o == '0);

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);

  // R1
  always_comb begin
    if (!rst_ni) reset_state_chk: assert (status[BANK_LO] == '0 && enable[BANK_HI] == '0 && !irq_o);
  end
endmodule

// File: tb/sim_irq_agg_ctrl.sv
module sim_irq_agg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lo_v = '0, hi_v = '0, wdata = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        err, irq;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_agg_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_lo_i(lo_v), .irq_hi_i(hi_v),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [31:0] m_st_lo, m_st_hi, m_en_lo, m_en_hi, m_pv_lo, m_pv_hi, m_rdata;
  logic        m_irq, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st_lo <= 0; m_st_hi <= 0; m_en_lo <= 0; m_en_hi <= 0;
      m_pv_lo <= 0; m_pv_hi <= 0; m_rdata <= 0; m_irq <= 0; m_err <= 0;
    end else begin
      logic [31:0] clr_lo, clr_hi, rv;
      bit known;
      clr_lo = (wr && addr == 8'h28) ? wdata : 0;
      clr_hi = (wr && addr == 8'h18) ? wdata : 0;
      m_st_lo <= (m_st_lo & ~clr_lo & ~(~lo_v & m_pv_lo)) | (lo_v & ~m_pv_lo);
      m_st_hi <= (m_st_hi & ~clr_hi & ~(~hi_v & m_pv_hi)) | (hi_v & ~m_pv_hi);
      m_pv_lo <= lo_v;
      m_pv_hi <= hi_v;
      if (wr && addr == 8'h24) m_en_lo <= wdata;
      if (wr && addr == 8'h14) m_en_hi <= wdata;
      m_irq <= ((m_st_lo & m_en_lo) != 0) || ((m_st_hi & m_en_hi) != 0);
      known = 1;
      rv = 0;
      case (addr)
        8'h10: rv = m_st_hi & m_en_hi;
        8'h14: rv = m_en_hi;
        8'h20: rv = m_st_lo & m_en_lo;
        8'h24: rv = m_en_lo;
        8'h18, 8'h1c, 8'h28, 8'h2c: rv = 0;
        default: known = 0;
      endcase
      m_rdata <= rd ? rv : 0;
      m_err   <= (rd || wr) && !known;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 irq_o vs model", {31'b0, irq}, {31'b0, m_irq});
      chk("R10 rdata_o vs model", rdata, m_rdata);
      chk("R9 err_o vs model", {31'b0, err}, {31'b0, m_err});
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1 addr = a; rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0; addr = '0;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(2);
    @(negedge clk);
    // R1
    chk("R1 irq_o in reset", {31'b0, irq}, 32'd0);
    chk("R1 rdata_o in reset", rdata, 32'd0);
    chk("R1 err_o in reset", {31'b0, err}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    bus_rd(8'h24, 32'h0, "R1 low enable after reset");
    bus_rd(8'h14, 32'h0, "R1 high enable after reset");

    // R2/R4: pending but not enabled reads zero
    @(posedge clk); #1 lo_v = 32'h0000_00F1;
    idle(2);
    bus_rd(8'h20, 32'h0, "R4 masked low status, enable zero");
    bus_wr(8'h24, 32'hFFFF_0011);
    bus_rd(8'h24, 32'hFFFF_0011, "R5 low enable readback");
    bus_rd(8'h20, 32'h0000_0011, "R4 masked low status");
    idle(1); @(negedge clk);
    chk("R3 irq_o raised by enable of pending line", {31'b0, irq}, 32'd1);
    bus_wr(8'h24, 32'h0F0F_0011);
    bus_rd(8'h24, 32'h0F0F_0011, "R5 whole-register replace");
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h20, 32'h0000_0011, "R4 write to status offset ignored");

    // R2: falling line clears
    @(posedge clk); #1 lo_v = 32'h0000_00F0;
    idle(2);
    bus_rd(8'h20, 32'h0000_0010, "R2 falling line clears status bit");

    // R6: write-one-to-clear while line stays high
    bus_wr(8'h28, 32'h0000_0010);
    bus_rd(8'h20, 32'h0, "R6 low clear write");
    bus_rd(8'h28, 32'h0, "R6 clear offset reads zero");
    idle(1); @(negedge clk);
    chk("R3 irq_o drops with last pending bit", {31'b0, irq}, 32'd0);

    // R7: rise and clear in the same cycle
    @(posedge clk); #1 lo_v = lo_v | 32'h0001_0000; addr = 8'h28; wdata = 32'h0001_0000; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0; addr = '0; wdata = '0;
    bus_rd(8'h20, 32'h0001_0000, "R7 rise beats clear");

    // R8: reserved offsets
    bus_wr(8'h1c, 32'hFFFF_FFFF);
    @(negedge clk); chk("R8 no err on reserved write", {31'b0, err}, 32'd0);
    bus_wr(8'h2c, 32'hFFFF_FFFF);
    bus_rd(8'h1c, 32'h0, "R8 reserved high reads zero");
    bus_rd(8'h2c, 32'h0, "R8 reserved low reads zero");
    bus_rd(8'h20, 32'h0001_0000, "R8 status unchanged after reserved writes");

    // R9: unmapped and unaligned
    bus_wr(8'h30, 32'hFFFF_FFFF);
    @(negedge clk); chk("R9 err after unmapped write", {31'b0, err}, 32'd1);
    bus_wr(8'h26, 32'h0);
    @(negedge clk); chk("R9 err after unaligned write", {31'b0, err}, 32'd1);
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h00, 32'h0, "R9 unmapped read is zero");
    bus_rd(8'h24, 32'h0F0F_0011, "R9 enable unchanged by stray writes");

    // high bank
    @(posedge clk); #1 hi_v = 32'h8000_0000;
    bus_wr(8'h14, 32'h8000_0000);
    bus_rd(8'h10, 32'h8000_0000, "R4 masked high status top bit");
    bus_rd(8'h14, 32'h8000_0000, "R5 high enable readback");
    bus_wr(8'h18, 32'h8000_0000);
    bus_rd(8'h10, 32'h0, "R6 high clear write");
    bus_wr(8'h24, 32'h0);
    idle(2); @(negedge clk);
    chk("R3 irq_o low with nothing enabled pending", {31'b0, irq}, 32'd0);

    // random mix, checked every cycle against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) lo_v = lo_v ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) hi_v = hi_v ^ (32'h1 << $urandom_range(0, 31));
      wr = 1'b0; rd = 1'b0;
      case ($urandom_range(0, 5))
        0: addr = 8'h10;
        1: addr = 8'h14;
        2: addr = 8'h18;
        3: addr = 8'h20;
        4: addr = 8'h24;
        default: addr = 8'h28;
      endcase
      if ($urandom_range(0, 9) == 0) addr = 8'($urandom_range(0, 63));
      wdata = $urandom();
      case ($urandom_range(0, 2))
        0: wr = 1'b1;
        1: rd = 1'b1;
        default: ;
      endcase
    end
    @(posedge clk); #1 wr = 1'b0; rd = 1'b0;
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule